// File: doc/BRIEF.md
# Three-Zone Asynchronous External Bus Bridge

This block connects a synchronous internal request port to an asynchronous parallel bus that serves external memories and peripherals. The upper three bits of a request address pick a zone. Zone numbers 0, 6 and 7 each own one active-low chip select. The other five zone numbers reach nothing, and a request to one of them completes at once with an error flag.

An accepted access runs through three timed phases: lead, active and trail. The chip select and the address stay put through all three phases. The read or write strobe is low only in the active phase. Each zone has its own lead, active and trail counts, with separate sets for reads and for writes. A per-zone enable lets an external ready pin stretch the active phase once the programmed count has run out.

The internal port handles one access at a time. It shows busy from acceptance until a one-cycle done pulse, which carries the read data and the error flag. A small configuration port loads the timing word of each zone.

Top module: `zoneBusBridge`

## Requirements
- R1: Request address bits [22:20] select the zone. Zone number 0 drives xCsN[0] low, zone 6 drives xCsN[1] low and zone 7 drives xCsN[2] low. Bits [19:0] appear on xAddr. At most one chip select is low at any time.
- R2: A request whose zone number is not 0, 6 or 7 produces doneValid with doneErr high in the first cycle after acceptance. No chip select and no strobe goes low for it.
- R3: A configuration write with cfgWe high stores cfgWord into one zone: cfgSel 0 picks zone 0, 1 picks zone 6, 2 picks zone 7, and 3 changes nothing. The word layout is as follows. Bits [2:0], [5:3] and [8:6] are the read lead, active and trail fields. Bits [11:9], [14:12] and [17:15] are the write lead, active and trail fields. Bit 18 is the ready enable. A field value v gives v+1 cycles. After reset every field is 0.
- R4: The chip select stays low for lead+active+trail cycles. The strobe (xRdN for reads, xWrN for writes) stays low for exactly the active cycles and starts in the cycle after the last lead cycle. The other strobe stays high.
- R5: xAddr and the chip select remain stable from the first lead cycle to the last trail cycle. All chip selects are high once the access ends.
- R6: For a write, xDataOe is high and xDataOut holds the request data in every lead, active and trail cycle. For a read, xDataOe stays low.
- R7: For a read, rdData equals the xDataIn value present in the last active cycle.
- R8: When the ready enable of a zone is set, the active phase ends only after its count has expired and the two-flop-synchronized xReady is high. If xReady rises in active cycle k, where k is at least the programmed count, the strobe lasts k+2 cycles. When the ready enable is clear, xReady has no effect.
- R9: portReady is low from acceptance until the done cycle, including that cycle. doneValid lasts one cycle, and portReady is high again in the cycle after it. The done cycle follows the last trail cycle directly.
- R10: After reset all chip selects and strobes are high, xDataOe is low, portReady is high and doneValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request strobe, taken when portReady is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 23 | Zone number [22:20] and external address [19:0] |
| reqWdata | input | 32 | Write data |
| portReady | output | 1 | High when a request can be accepted |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Zone miss flag, valid with doneValid |
| rdData | output | 32 | Read data, valid with doneValid |
| cfgWe | input | 1 | Configuration write enable |
| cfgSel | input | 2 | Zone slot for the configuration write |
| cfgWord | input | 19 | Timing and ready-enable word |
| xAddr | output | 20 | External address |
| xDataOut | output | 32 | External write data |
| xDataOe | output | 1 | External data drive enable |
| xDataIn | input | 32 | External read data |
| xCsN | output | 3 | Active-low chip selects for zones 0, 6, 7 |
| xRdN | output | 1 | Active-low read strobe |
| xWrN | output | 1 | Active-low write strobe |
| xReady | input | 1 | Asynchronous external ready |

## Verification
The assertions assume three things about the inputs:
- reset is held low at start-up;
- reqValid matters only while portReady is high;
- xDataIn is steady around the edge that ends the active phase.

The bench raises requests only after it has seen portReady high. It writes the configuration only between accesses. It drives xDataIn as a function of the address while xRdN is low and as a marker pattern otherwise, so a capture made too early or too late shows up in rdData. xReady changes only on falling edges, which makes the synchronizer delay exact enough to predict the stretched strobe length.

// File: rtl/zoneBusPkg.sv
package zoneBusPkg;
  localparam int ZONE_COUNT = 3;
  localparam int IDX_W = $clog2(ZONE_COUNT);
  localparam int CNT_W = 3;
  localparam int ZSEL_W = 3;

  typedef struct packed {
    logic [CNT_W-1:0] trail;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] lead;
  } phaseCfg_t;

  typedef struct packed {
    logic      readyEn;
    phaseCfg_t wr;
    phaseCfg_t rd;
  } zoneCfg_t;

  localparam int CFG_W = $bits(zoneCfg_t);

  typedef struct packed {
    logic loadReq;
    logic latchRd;
    logic busOn;
    logic strobeOn;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_ACTIVE, ST_TRAIL, ST_DONE
  } phase_e;

  // zone number to one-hot chip-select slot; unmapped numbers give zero
  function automatic logic [ZONE_COUNT-1:0] zoneHotOf(input logic [ZSEL_W-1:0] num);
    logic [ZONE_COUNT-1:0] hot;
    case (num)
      3'd0:    hot = 3'b001;
      3'd6:    hot = 3'b010;
      3'd7:    hot = 3'b100;
      default: hot = 3'b000;
    endcase
    return hot;
  endfunction

  function automatic logic [IDX_W-1:0] hotToIdx(input logic [ZONE_COUNT-1:0] hot);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < ZONE_COUNT; i++)
      if (hot[i]) idx = IDX_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/zoneCfgRegs.sv
module zoneCfgRegs
  import zoneBusPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [1:0]                  cfgSel,
  input  zoneCfg_t                    cfgWord,
  output zoneCfg_t [ZONE_COUNT-1:0]   cfgArr
);
  for (genvar z = 0; z < ZONE_COUNT; z++) begin : gZone
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgArr[z] <= '0;
      else if (cfgWe && cfgSel == 2'(z))
        cfgArr[z] <= cfgWord;
    end
  end
endmodule

// File: rtl/zoneBusCtrl.sv
module zoneBusCtrl
  import zoneBusPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [ZSEL_W-1:0]         reqZoneNum,
  input  zoneCfg_t [ZONE_COUNT-1:0] cfgArr,
  input  logic                      xReady,
  output logic                      portReady,
  output logic                      doneValid,
  output logic                      doneErr,
  output dpCtl_t                    dpCtl
);
  phase_e            state;
  logic [CNT_W-1:0]  cnt;
  phaseCfg_t         phaseQ;
  logic              readyEnQ;
  logic              errQ;
  logic              syncStage1;
  logic              readySync;

  logic [ZONE_COUNT-1:0] reqHot;
  logic                  reqHit;
  logic [IDX_W-1:0]      reqIdx;
  zoneCfg_t              reqCfg;
  phaseCfg_t             reqPhase;
  logic                  accept;
  logic                  activeExit;

  always_comb begin
    reqHot     = zoneHotOf(reqZoneNum);
    reqHit     = |reqHot;
    reqIdx     = hotToIdx(reqHot);
    reqCfg     = cfgArr[reqIdx];
    reqPhase   = reqWrite ? reqCfg.wr : reqCfg.rd;
    portReady  = (state == ST_IDLE);
    accept     = portReady && reqValid;
    activeExit = (state == ST_ACTIVE) && (cnt == '0) && (!readyEnQ || readySync);
    doneValid  = (state == ST_DONE);
    doneErr    = doneValid && errQ;
  end

  always_comb begin
    dpCtl.loadReq  = accept && reqHit;
    dpCtl.latchRd  = activeExit;
    dpCtl.busOn    = (state == ST_LEAD) || (state == ST_ACTIVE) || (state == ST_TRAIL);
    dpCtl.strobeOn = (state == ST_ACTIVE);
  end

  // two-flop synchronizer for the asynchronous ready pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage1 <= 1'b0;
      readySync  <= 1'b0;
    end else begin
      syncStage1 <= xReady;
      readySync  <= syncStage1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      phaseQ   <= '0;
      readyEnQ <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (reqHit) begin
              state    <= ST_LEAD;
              cnt      <= reqPhase.lead;
              phaseQ   <= reqPhase;
              readyEnQ <= reqCfg.readyEn;
              errQ     <= 1'b0;
            end else begin
              state <= ST_DONE;
              errQ  <= 1'b1;
            end
          end
        end
        ST_LEAD: begin
          if (cnt == '0) begin
            state <= ST_ACTIVE;
            cnt   <= phaseQ.active;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (activeExit) begin
            state <= ST_TRAIL;
            cnt   <= phaseQ.trail;
          end
        end
        ST_TRAIL: begin
          if (cnt == '0) state <= ST_DONE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_miss_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !reqHit) |=> (doneValid && doneErr));

  assert_wait_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && cnt != '0) |=> (state == ST_ACTIVE));

  assert_ready_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && readyEnQ && !readySync) |=> (state == ST_ACTIVE));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_busy_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> portReady);
endmodule

// File: rtl/zoneBusDatapath.sv
module zoneBusDatapath
  import zoneBusPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    dpCtl,
  input  logic                      reqWrite,
  input  logic [ADDR_W+ZSEL_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [DATA_W-1:0]         xDataIn,
  output logic [DATA_W-1:0]         rdData,
  output logic [ADDR_W-1:0]         xAddr,
  output logic [DATA_W-1:0]         xDataOut,
  output logic                      xDataOe,
  output logic [ZONE_COUNT-1:0]     xCsN,
  output logic                      xRdN,
  output logic                      xWrN
);
  logic [ADDR_W-1:0]     addrQ;
  logic [DATA_W-1:0]     wdataQ;
  logic [DATA_W-1:0]     rdataQ;
  logic [ZONE_COUNT-1:0] zoneHotQ;
  logic                  writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      zoneHotQ <= '0;
      writeQ   <= 1'b0;
    end else if (dpCtl.loadReq) begin
      addrQ    <= reqAddr[ADDR_W-1:0];
      wdataQ   <= reqWdata;
      zoneHotQ <= zoneHotOf(reqAddr[ADDR_W +: ZSEL_W]);
      writeQ   <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           rdataQ <= '0;
    else if (dpCtl.latchRd && !writeQ)   rdataQ <= xDataIn;
  end

  always_comb begin
    xAddr    = addrQ;
    xDataOut = wdataQ;
    xDataOe  = dpCtl.busOn && writeQ;
    xCsN     = ~(zoneHotQ & {ZONE_COUNT{dpCtl.busOn}});
    xRdN     = ~(dpCtl.strobeOn && !writeQ);
    xWrN     = ~(dpCtl.strobeOn && writeQ);
    rdData   = rdataQ;
  end

  assert_single_cs_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~xCsN));

  assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!xRdN || !xWrN) |-> (xCsN != '1));

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dpCtl.busOn) && dpCtl.busOn) |-> ($stable(xAddr) && $stable(xCsN)));

  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(xDataOe) && xDataOe) |-> $stable(xDataOut));
endmodule

// File: rtl/zoneBusBridge.sv
module zoneBusBridge
  import zoneBusPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [ADDR_W+ZSEL_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  output logic                      portReady,
  output logic                      doneValid,
  output logic                      doneErr,
  output logic [DATA_W-1:0]         rdData,
  input  logic                      cfgWe,
  input  logic [1:0]                cfgSel,
  input  logic [CFG_W-1:0]          cfgWord,
  output logic [ADDR_W-1:0]         xAddr,
  output logic [DATA_W-1:0]         xDataOut,
  output logic                      xDataOe,
  input  logic [DATA_W-1:0]         xDataIn,
  output logic [ZONE_COUNT-1:0]     xCsN,
  output logic                      xRdN,
  output logic                      xWrN,
  input  logic                      xReady
);
  zoneCfg_t [ZONE_COUNT-1:0] cfgArr;
  dpCtl_t                    dpCtl;

  zoneCfgRegs regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .cfgWord (zoneCfg_t'(cfgWord)),
    .cfgArr  (cfgArr)
  );

  zoneBusCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqZoneNum (reqAddr[ADDR_W +: ZSEL_W]),
    .cfgArr     (cfgArr),
    .xReady     (xReady),
    .portReady  (portReady),
    .doneValid  (doneValid),
    .doneErr    (doneErr),
    .dpCtl      (dpCtl)
  );

  zoneBusDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .xDataIn  (xDataIn),
    .rdData   (rdData),
    .xAddr    (xAddr),
    .xDataOut (xDataOut),
    .xDataOe  (xDataOe),
    .xCsN     (xCsN),
    .xRdN     (xRdN),
    .xWrN     (xWrN)
  );
endmodule

// File: tb/zoneBusBridge_tb_top.sv
`timescale 1ns/1ps
module zoneBusBridge_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [22:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        portReady, doneValid, doneErr;
  logic [31:0] rdData;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [18:0] cfgWord = '0;
  logic [19:0] xAddr;
  logic [31:0] xDataOut;
  logic        xDataOe;
  logic [31:0] xDataIn;
  logic [2:0]  xCsN;
  logic        xRdN, xWrN;
  logic        xReady = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [18:0] cfgModel [3];

  always #10 clk = ~clk;

  function automatic logic [31:0] extModel(input logic [19:0] a);
    return {a[11:0], a} ^ 32'h3C96_0F1E;
  endfunction

  assign xDataIn = (!xRdN) ? extModel(xAddr) : 32'hDEAD_BEEF;

  zoneBusBridge dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .portReady(portReady),
    .doneValid(doneValid), .doneErr(doneErr), .rdData(rdData),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWord(cfgWord),
    .xAddr(xAddr), .xDataOut(xDataOut), .xDataOe(xDataOe), .xDataIn(xDataIn),
    .xCsN(xCsN), .xRdN(xRdN), .xWrN(xWrN), .xReady(xReady)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mkCfg(input int rl, input int ra, input int rt,
                                         input int wl, input int wa, input int wt,
                                         input bit re);
    return {re, 3'(wt-1), 3'(wa-1), 3'(wl-1), 3'(rt-1), 3'(ra-1), 3'(rl-1)};
  endfunction

  task automatic writeCfg(input logic [1:0] sel, input logic [18:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWord = w;
    @(negedge clk);
    cfgWe = 1'b0;
    if (sel != 2'd3) cfgModel[sel] = w;
  endtask

  // readyMode: 0 = ready high, 1 = low then raised in active cycle 12, 2 = always low
  task automatic runAccess(input bit wr, input logic [2:0] zn, input logic [19:0] ad,
                           input logic [31:0] wd, input int readyMode);
    int idx, lc, ac, tc, expBus, expAct;
    int busCyc, csCyc, strobeCyc, firstStrobe, guard;
    bit miss, csBad, addrBad, dataBad, otherBad, busyBad;
    logic [2:0] expCsN;
    logic [18:0] w;
    case (zn)
      3'd0: idx = 0;
      3'd6: idx = 1;
      3'd7: idx = 2;
      default: idx = -1;
    endcase
    miss = (idx < 0);
    lc = 0; ac = 0; tc = 0; expCsN = 3'b111;
    if (!miss) begin
      w = cfgModel[idx];
      lc = int'(wr ? w[11:9]  : w[2:0]) + 1;
      ac = int'(wr ? w[14:12] : w[5:3]) + 1;
      tc = int'(wr ? w[17:15] : w[8:6]) + 1;
      expCsN = ~(3'b001 << idx);
    end
    expAct = (readyMode == 1) ? 14 : ac;
    expBus = miss ? 0 : lc + expAct + tc;

    @(negedge clk);
    chk(portReady == 1'b1, "R9 idle ready", portReady, 1);
    xReady = (readyMode == 0);
    reqValid = 1'b1; reqWrite = wr; reqAddr = {zn, ad}; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    busCyc = 0; csCyc = 0; strobeCyc = 0; firstStrobe = 0; guard = 0;
    csBad = 0; addrBad = 0; dataBad = 0; otherBad = 0; busyBad = 0;
    while (!doneValid && guard < 200) begin
      busCyc++;
      if (xCsN != 3'b111) csCyc++;
      if (xCsN != expCsN) csBad = 1;
      if (xAddr != ad) addrBad = 1;
      if (wr && !(xDataOe && xDataOut == wd)) dataBad = 1;
      if (!wr && xDataOe) dataBad = 1;
      if (portReady) busyBad = 1;
      if ((wr && !xRdN) || (!wr && !xWrN)) otherBad = 1;
      if ((wr && !xWrN) || (!wr && !xRdN)) begin
        strobeCyc++;
        if (firstStrobe == 0) firstStrobe = busCyc;
        if (readyMode == 1 && strobeCyc == 12) xReady = 1'b1;
      end
      @(negedge clk);
      guard++;
    end
    chk(guard < 200, "R9 completion", guard, expBus);
    chk(doneErr == miss, "R2 error flag", doneErr, miss);
    chk(csCyc == expBus, "R4 chip-select cycles", csCyc, expBus);
    chk(strobeCyc == expAct, "R8 strobe cycles", strobeCyc, expAct);
    chk(xCsN == 3'b111 && xRdN && xWrN, "R5 bus released at done", xCsN, 7);
    if (!miss) begin
      chk(!csBad, "R1 chip-select decode", csBad, 0);
      chk(!addrBad, "R5 address held", addrBad, 0);
      chk(!dataBad, "R6 write data drive", dataBad, 0);
      chk(!otherBad, "R4 wrong strobe", otherBad, 0);
      chk(!busyBad, "R9 busy during access", busyBad, 0);
      chk(firstStrobe == lc + 1, "R3 lead length", firstStrobe, lc + 1);
      if (!wr) chk(rdData == extModel(ad), "R7 read capture", rdData, extModel(ad));
    end
    chk(portReady == 1'b0, "R9 busy in done cycle", portReady, 0);
    @(negedge clk);
    chk(!doneValid && portReady, "R9 single done pulse", doneValid, 0);
    xReady = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd20240611);
    for (int i = 0; i < 3; i++) cfgModel[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(xCsN == 3'b111, "R10 chip selects idle", xCsN, 7);
    chk(xRdN && xWrN, "R10 strobes idle", {xRdN, xWrN}, 3);
    chk(!xDataOe, "R10 no drive", xDataOe, 0);
    chk(portReady && !doneValid, "R10 port idle", {portReady, doneValid}, 2);
    rstN = 1'b1;
    @(negedge clk);

    // R1 default one-cycle phases on each zone
    runAccess(1'b0, 3'd0, 20'h12345, 32'h0, 0);
    runAccess(1'b1, 3'd6, 20'hABCDE, 32'hCAFE_F00D, 0);
    runAccess(1'b0, 3'd7, 20'h00001, 32'h0, 0);
    // R3 maximum counts, separate read and write fields
    writeCfg(2'd2, mkCfg(8, 8, 8, 2, 5, 3, 1'b0));
    runAccess(1'b0, 3'd7, 20'hFFFFF, 32'h0, 0);
    runAccess(1'b1, 3'd7, 20'h80000, 32'h1234_5678, 0);
    // R2 unmapped zone numbers
    runAccess(1'b0, 3'd3, 20'h55555, 32'h0, 0);
    runAccess(1'b1, 3'd1, 20'h00000, 32'hFFFF_FFFF, 0);
    // R8 ready stretch and ready ignored when disabled
    writeCfg(2'd1, mkCfg(2, 3, 2, 1, 1, 1, 1'b1));
    runAccess(1'b0, 3'd6, 20'h0F0F0, 32'h0, 1);
    writeCfg(2'd0, mkCfg(3, 4, 1, 2, 2, 2, 1'b0));
    runAccess(1'b0, 3'd0, 20'h33333, 32'h0, 2);
    runAccess(1'b1, 3'd0, 20'h44444, 32'h0BAD_CAFE, 2);
    // R3 slot 3 writes change nothing
    writeCfg(2'd3, 19'h7FFFF);
    runAccess(1'b0, 3'd0, 20'h76543, 32'h0, 0);
    runAccess(1'b0, 3'd6, 20'h76543, 32'h0, 0);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      for (int z = 0; z < 3; z++)
        writeCfg(2'(z), 19'($urandom()));
      for (int k = 0; k < 6; k++) begin
        logic [2:0] zn;
        int pick;
        pick = int'($urandom_range(0, 9));
        zn = (pick < 3) ? 3'd0 : (pick < 6) ? 3'd6 : (pick < 9) ? 3'd7 : 3'($urandom_range(1, 5));
        runAccess(1'($urandom()), zn, 20'($urandom()), $urandom(), 0);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule